// File: doc/BRIEF.md
# Bit-parallel graph genotype evaluator

This block runs a candidate circuit that is stored as a flat list of small integers. The circuit is a feed-forward grid of two-input logic nodes with a fixed number of rows and columns. A levels-back limit sets how far to the left a node may take its inputs. Each primary input arrives as a 32-bit word, and bit position r of that word holds the input's value on truth-table row r. Every node therefore produces 32 rows of its truth table in one operation.

The genotype is loaded word by word through a write port while the block is idle. A start pulse then sets three phases running. In the first phase the nodes are evaluated in list order (column-major), one node per clock, and the results go into a value store. In the second phase the selected output words are gathered. In the third phase a backward sweep marks which nodes feed any output, and the marked nodes are counted. A genotype that breaks the connectivity rules ends the run early with an error flag.

Top module: `geno_eval`

## Requirements
- R1: After reset, done and err are low, every output word is zero and active_cnt is zero.
- R2: Function codes: 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 XNOR, 6 first AND NOT second, 7 pass first, 8 pass second. Any other code gives an all-zero word.
- R3: Value index i < N_IN selects input word i, which is bits [i*W +: W] of in_words. Node k has value index N_IN+k and sits in column k / N_ROWS. Node k's first source is at gene address 3k, its second source at 3k+1 and its function at 3k+2. Output selector j is at address 3*N_NODE+j. Bit r of every word is truth-table row r.
- R4: After a legal run, output word j (bits [j*W +: W] of out_words) equals the value that selector j names.
- R5: After a legal run, active_cnt equals the number of nodes that reach some selected output, directly or through other nodes.
- R6: A node source is legal if it is a primary input, or if it is a node in a column strictly to the left that lies no more than LEVELS_BACK columns away. A source in the same column, in a column to the right, too far to the left, or with an index of N_IN+N_NODE or more raises err together with done, with all output words and active_cnt zero.
- R7: An output selector must name a node in the last LEVELS_BACK columns. It may name a primary input only when LEVELS_BACK >= N_COLS. Any other selector raises err in the same way as R6.
- R8: For a legal genotype, done rises 2*N_NODE+2 clock edges after the edge that samples start, counting that edge as the first. The edge that accepts start clears done and err. While idle, done and the results hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gene_we | input | 1 | Genotype write enable, taken only while idle |
| gene_addr | input | GAW | Genotype word address |
| gene_data | input | DW | Genotype word |
| start | input | 1 | Start an evaluation, taken only while idle |
| in_words | input | N_IN*W | Primary input words, held stable during a run |
| out_words | output | N_OUT*W | Gathered output words |
| active_cnt | output | CW | Number of active nodes |
| done | output | 1 | Run finished, held until next start |
| err | output | 1 | Genotype broke a connectivity rule |

## Verification
The assertions check on every cycle that an error result is always flagged as done and always carries zeroed outputs and count, and that the count never exceeds the node total. They also check that accepting a start clears the previous result, that idle results hold, and that a legal run completes with its exact latency. Only the bench's scenarios can show that the 32-row words match the logic functions. The same holds for the gathered outputs naming the right values and for the backward sweep counting the right nodes. Those scenarios cover a sweep of every function code, many random legal grids, and one illegal link of each kind.

// File: rtl/geno_eval_pkg.sv
package geno_eval_pkg;
  localparam int FN_W = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_OUTS, ST_SWEEP} phase_t;

  localparam logic [FN_W-1:0] FN_AND   = 4'd0;
  localparam logic [FN_W-1:0] FN_OR    = 4'd1;
  localparam logic [FN_W-1:0] FN_XOR   = 4'd2;
  localparam logic [FN_W-1:0] FN_NAND  = 4'd3;
  localparam logic [FN_W-1:0] FN_NOR   = 4'd4;
  localparam logic [FN_W-1:0] FN_XNOR  = 4'd5;
  localparam logic [FN_W-1:0] FN_ANDN  = 4'd6;
  localparam logic [FN_W-1:0] FN_PASSA = 4'd7;
  localparam logic [FN_W-1:0] FN_PASSB = 4'd8;
endpackage

// File: rtl/geno_node_alu.sv
module geno_node_alu
  import geno_eval_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [FN_W-1:0] fn,
  output logic [W-1:0]    y
);
  always_comb begin
    case (fn)
      FN_AND:   y = a & b;
      FN_OR:    y = a | b;
      FN_XOR:   y = a ^ b;
      FN_NAND:  y = ~(a & b);
      FN_NOR:   y = ~(a | b);
      FN_XNOR:  y = ~(a ^ b);
      FN_ANDN:  y = a & ~b;
      FN_PASSA: y = a;
      FN_PASSB: y = b;
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/geno_gene_store.sv
module geno_gene_store #(
  parameter int N_NODE = 8,
  parameter int N_OUT  = 2,
  parameter int DW     = 4,
  parameter int GAW    = 5,
  parameter int NIW    = 3
) (
  input  logic                clk,
  input  logic                we,
  input  logic [GAW-1:0]      waddr,
  input  logic [DW-1:0]       wdata,
  input  logic [NIW-1:0]      node_sel,
  output logic [DW-1:0]       src_a,
  output logic [DW-1:0]       src_b,
  output logic [DW-1:0]       fn,
  output logic [N_OUT*DW-1:0] out_sel
);
  localparam int G = 3 * N_NODE + N_OUT;

  logic [DW-1:0]  mem [G];
  logic [GAW-1:0] base;

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < G)) mem[waddr] <= wdata;
  end

  assign base  = GAW'(node_sel) * GAW'(3);
  assign src_a = mem[base];
  assign src_b = mem[base + GAW'(1)];
  assign fn    = mem[base + GAW'(2)];

  for (genvar j = 0; j < N_OUT; j++) begin : g_osel
    assign out_sel[j*DW +: DW] = mem[3*N_NODE + j];
  end
endmodule

// File: rtl/geno_link_chk.sv
module geno_link_chk #(
  parameter int N_IN     = 4,
  parameter int N_ROWS   = 2,
  parameter int N_COLS   = 4,
  parameter int LB       = 2,
  parameter int DW       = 4,
  parameter int NIW      = 3,
  parameter bit OUT_MODE = 1'b0
) (
  input  logic [DW-1:0]  src,
  input  logic [NIW-1:0] node,
  output logic           ok
);
  localparam int N_VAL = N_IN + N_ROWS * N_COLS;

  int s, sc, kc;
  logic ok_node, ok_out;

  always_comb begin
    s  = int'(src);
    kc = int'(node) / N_ROWS;
    sc = (s - N_IN) / N_ROWS;
    ok_node = (s < N_IN) || ((s < N_VAL) && (sc < kc) && ((kc - sc) <= LB));
    ok_out  = (s < N_VAL) && ((s < N_IN) ? (LB >= N_COLS) : (sc >= N_COLS - LB));
    ok = OUT_MODE ? ok_out : ok_node;
  end
endmodule

// File: rtl/geno_eval.sv
module geno_eval
  import geno_eval_pkg::*;
#(
  parameter  int W           = 32,
  parameter  int N_IN        = 4,
  parameter  int N_ROWS      = 2,
  parameter  int N_COLS      = 4,
  parameter  int LEVELS_BACK = 2,
  parameter  int N_OUT       = 2,
  localparam int N_NODE = N_ROWS * N_COLS,
  localparam int N_VAL  = N_IN + N_NODE,
  localparam int IDX_W  = $clog2(N_VAL),
  localparam int DW     = (IDX_W > FN_W) ? IDX_W : FN_W,
  localparam int G      = 3 * N_NODE + N_OUT,
  localparam int GAW    = $clog2(G),
  localparam int NIW    = (N_NODE > 1) ? $clog2(N_NODE) : 1,
  localparam int CW     = $clog2(N_NODE + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gene_we,
  input  logic [GAW-1:0]     gene_addr,
  input  logic [DW-1:0]      gene_data,
  input  logic               start,
  input  logic [N_IN*W-1:0]  in_words,
  output logic [N_OUT*W-1:0] out_words,
  output logic [CW-1:0]      active_cnt,
  output logic               done,
  output logic               err
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_ff;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_i = rst_ff[1];

  phase_t              st, st_nx;
  logic [NIW-1:0]      idx, idx_nx;
  logic [N_NODE-1:0]   act, act_nx;
  logic [CW-1:0]       cnt, cnt_nx;
  logic [N_OUT*W-1:0]  out_q, out_nx;
  logic                done_q, done_nx, err_q, err_nx;
  logic                val_we, busy;
  logic [W-1:0]        vals [N_NODE];

  logic [DW-1:0]       g_a, g_b, g_fn;
  logic [N_OUT*DW-1:0] g_out;
  logic [W-1:0]        opa, opb, alu_y;
  logic                ok_a, ok_b;
  logic [N_OUT-1:0]    ok_o;

  assign busy = (st != ST_IDLE);

  geno_gene_store #(.N_NODE(N_NODE), .N_OUT(N_OUT), .DW(DW), .GAW(GAW), .NIW(NIW)) u_genes (
    .clk(clk), .we(gene_we && !busy), .waddr(gene_addr), .wdata(gene_data),
    .node_sel(idx), .src_a(g_a), .src_b(g_b), .fn(g_fn), .out_sel(g_out));

  geno_link_chk #(.N_IN(N_IN), .N_ROWS(N_ROWS), .N_COLS(N_COLS), .LB(LEVELS_BACK),
    .DW(DW), .NIW(NIW), .OUT_MODE(1'b0)) u_lnk_a (.src(g_a), .node(idx), .ok(ok_a));
  geno_link_chk #(.N_IN(N_IN), .N_ROWS(N_ROWS), .N_COLS(N_COLS), .LB(LEVELS_BACK),
    .DW(DW), .NIW(NIW), .OUT_MODE(1'b0)) u_lnk_b (.src(g_b), .node(idx), .ok(ok_b));

  for (genvar j = 0; j < N_OUT; j++) begin : g_olnk
    geno_link_chk #(.N_IN(N_IN), .N_ROWS(N_ROWS), .N_COLS(N_COLS), .LB(LEVELS_BACK),
      .DW(DW), .NIW(NIW), .OUT_MODE(1'b1)) u_lnk_o (
      .src(g_out[j*DW +: DW]), .node(NIW'(0)), .ok(ok_o[j]));
  end

  function automatic logic [W-1:0] pick(input logic [DW-1:0] s);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < N_IN; i++)   if (int'(s) == i)        r = in_words[i*W +: W];
    for (int n = 0; n < N_NODE; n++) if (int'(s) == N_IN + n) r = vals[n];
    return r;
  endfunction

  function automatic logic [N_NODE-1:0] mark(input logic [DW-1:0] s);
    logic [N_NODE-1:0] m;
    m = '0;
    for (int n = 0; n < N_NODE; n++) if (int'(s) == N_IN + n) m[n] = 1'b1;
    return m;
  endfunction

  assign opa = pick(g_a);
  assign opb = pick(g_b);

  geno_node_alu #(.W(W)) u_alu (.a(opa), .b(opb), .fn(g_fn[FN_W-1:0]), .y(alu_y));

  // next-state process
  always_comb begin
    st_nx = st; idx_nx = idx; act_nx = act; cnt_nx = cnt;
    out_nx = out_q; done_nx = done_q; err_nx = err_q; val_we = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        st_nx = ST_EVAL; idx_nx = '0; act_nx = '0; cnt_nx = '0;
        out_nx = '0; done_nx = 1'b0; err_nx = 1'b0;
      end
      ST_EVAL: begin
        if (!(ok_a && ok_b)) begin
          err_nx = 1'b1; done_nx = 1'b1; st_nx = ST_IDLE;
        end else begin
          val_we = 1'b1;
          if (int'(idx) == N_NODE - 1) st_nx = ST_OUTS;
          else                         idx_nx = idx + NIW'(1);
        end
      end
      ST_OUTS: begin
        if (!(&ok_o)) begin
          err_nx = 1'b1; done_nx = 1'b1; st_nx = ST_IDLE;
        end else begin
          for (int j = 0; j < N_OUT; j++) begin
            out_nx[j*W +: W] = pick(g_out[j*DW +: DW]);
            act_nx = act_nx | mark(g_out[j*DW +: DW]);
          end
          idx_nx = NIW'(N_NODE - 1);
          st_nx  = ST_SWEEP;
        end
      end
      ST_SWEEP: begin
        if (act[idx]) begin
          cnt_nx = cnt + CW'(1);
          act_nx = act | mark(g_a) | mark(g_b);
        end
        if (idx == '0) begin
          done_nx = 1'b1; st_nx = ST_IDLE;
        end else begin
          idx_nx = idx - NIW'(1);
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  // value store, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (val_we) vals[idx] <= alu_y;
  end

  // register process
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st <= ST_IDLE; idx <= '0; act <= '0; cnt <= '0;
      out_q <= '0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st <= st_nx; idx <= idx_nx; act <= act_nx; cnt <= cnt_nx;
      out_q <= out_nx; done_q <= done_nx; err_q <= err_nx;
    end
  end

  assign out_words  = out_q;
  assign active_cnt = cnt;
  assign done       = done_q;
  assign err        = err_q;
endmodule

// File: rtl/geno_eval_chk.sv
module geno_eval_chk #(
  parameter int W      = 32,
  parameter int N_OUT  = 2,
  parameter int N_NODE = 8,
  parameter int CW     = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               err,
  input logic [N_OUT*W-1:0] out_words,
  input logic [CW-1:0]      active_cnt
);
  localparam int LW = $clog2(2 * N_NODE + 4);
  logic [LW-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lat <= '0;
    else if (start && !busy) lat <= '0;
    else if (busy)           lat <= lat + LW'(1);
  end

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R6
  AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (out_words == '0 && active_cnt == '0)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active_cnt <= CW'(N_NODE)); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (!done && !err && busy)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(out_words) && $stable(active_cnt))); // R8
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !err) |-> (lat == LW'(2 * N_NODE + 1))); // R8
endmodule

bind geno_eval geno_eval_chk #(.W(W), .N_OUT(N_OUT), .N_NODE(N_NODE), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_i), .start(start), .busy(busy), .done(done), .err(err),
  .out_words(out_words), .active_cnt(active_cnt));

// File: tb/test_geno_eval.sv
module test_geno_eval;
  localparam int CLK_P = 10;
  localparam int NIN = 4, NR = 2, NC = 4, LB = 2, NO = 2;
  localparam int NN = NR * NC, NV = NIN + NN, NG = 3 * NN + NO;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         gene_we = 1'b0;
  logic [4:0]   gene_addr = '0;
  logic [3:0]   gene_data = '0;
  logic         start = 1'b0;
  logic [127:0] in_words = '0;
  logic [63:0]  out_words;
  logic [3:0]   active_cnt;
  logic         done, err;

  int total = 0, bad = 0;
  int g[NG];
  logic [31:0] inw[NIN];

  always #(CLK_P/2) clk = ~clk;

  geno_eval i_geno_eval (
    .clk(clk), .rst_n(rst_n), .gene_we(gene_we), .gene_addr(gene_addr),
    .gene_data(gene_data), .start(start), .in_words(in_words),
    .out_words(out_words), .active_cnt(active_cnt), .done(done), .err(err));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fn_ref(input int f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      0: return a & b;
      1: return a | b;
      2: return a ^ b;
      3: return ~(a & b);
      4: return ~(a | b);
      5: return ~(a ^ b);
      6: return a & ~b;
      7: return a;
      8: return b;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit legal_src(input int s, input int k);
    int sc, kc;
    if (s < 0 || s >= NV) return 1'b0;
    if (s < NIN) return 1'b1;
    sc = (s - NIN) / NR;
    kc = k / NR;
    return (sc < kc) && (kc - sc <= LB);
  endfunction

  function automatic bit legal_out(input int s);
    if (s < 0 || s >= NV) return 1'b0;
    if (s < NIN) return LB >= NC;
    return ((s - NIN) / NR) >= NC - LB;
  endfunction

  task automatic rand_geno();
    for (int k = 0; k < NN; k++) begin
      for (int p = 0; p < 2; p++) begin
        int s;
        s = $urandom_range(NV - 1, 0);
        while (!legal_src(s, k)) s = $urandom_range(NV - 1, 0);
        g[3*k+p] = s;
      end
      g[3*k+2] = $urandom_range(15, 0);
    end
    for (int j = 0; j < NO; j++) begin
      int s;
      s = $urandom_range(NV - 1, 0);
      while (!legal_out(s)) s = $urandom_range(NV - 1, 0);
      g[3*NN+j] = s;
    end
  endtask

  task automatic run_geno(input string etag);
    logic [31:0] v[NV];
    bit          a[NN];
    bit          e_err;
    int          e_cnt, n;
    logic [63:0] held;
    e_err = 1'b0;
    for (int i = 0; i < NIN; i++) v[i] = inw[i];
    for (int k = 0; k < NN; k++) begin
      if (!legal_src(g[3*k], k) || !legal_src(g[3*k+1], k)) e_err = 1'b1;
      v[NIN+k] = e_err ? 32'h0 : fn_ref(g[3*k+2], v[g[3*k]], v[g[3*k+1]]);
      a[k] = 1'b0;
    end
    for (int j = 0; j < NO; j++) if (!legal_out(g[3*NN+j])) e_err = 1'b1;
    e_cnt = 0;
    if (!e_err) begin
      for (int j = 0; j < NO; j++) if (g[3*NN+j] >= NIN) a[g[3*NN+j]-NIN] = 1'b1;
      for (int k = NN - 1; k >= 0; k--) if (a[k]) begin
        e_cnt++;
        if (g[3*k] >= NIN)   a[g[3*k]-NIN] = 1'b1;
        if (g[3*k+1] >= NIN) a[g[3*k+1]-NIN] = 1'b1;
      end
    end
    for (int i = 0; i < NIN; i++) in_words[i*32 +: 32] = inw[i];
    for (int ad = 0; ad < NG; ad++) begin
      @(negedge clk);
      gene_we = 1'b1; gene_addr = 5'(ad); gene_data = 4'(g[ad]);
    end
    @(negedge clk);
    gene_we = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; n = 1;
    chk("R8 done cleared by start", {63'd0, done}, 64'd0);
    while (!done && n < 1000) begin @(negedge clk); n++; end
    if (n >= 1000) chk("R8 watchdog run", 64'd0, 64'd1);
    if (e_err) begin
      chk({etag, " err"}, {63'd0, err}, 64'd1);
      chk({etag, " outputs zero"}, out_words, 64'd0);
      chk({etag, " count zero"}, {60'd0, active_cnt}, 64'd0);
    end else begin
      chk("R6 no err on legal", {63'd0, err}, 64'd0);
      chk("R4 out word 0", {32'd0, out_words[31:0]}, {32'd0, v[g[3*NN]]});
      chk("R4 out word 1", {32'd0, out_words[63:32]}, {32'd0, v[g[3*NN+1]]});
      chk("R5 active count", {60'd0, active_cnt}, 64'(e_cnt));
      chk("R8 latency", 64'(n), 64'(2*NN+2));
    end
    held = out_words;
    repeat (2) @(negedge clk);
    chk("R8 done held", {63'd0, done}, 64'd1);
    chk("R8 result held", out_words, held);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R3 truth-table input patterns: bit r of input v is bit v of r
    inw[0] = 32'hAAAAAAAA; inw[1] = 32'hCCCCCCCC;
    inw[2] = 32'hF0F0F0F0; inw[3] = 32'hFF00FF00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 err", {63'd0, err}, 64'd0);
    chk("R1 outputs", out_words, 64'd0);
    chk("R1 count", {60'd0, active_cnt}, 64'd0);

    // R2 R3: every function code on node 0, carried to the right edge
    for (int f = 0; f < 16; f++) begin
      for (int k = 0; k < NN; k++) begin g[3*k] = 0; g[3*k+1] = 0; g[3*k+2] = 0; end
      g[0] = 0; g[1] = 1; g[2] = f;
      g[6] = 4;  g[8] = 7;
      g[12] = 6; g[14] = 7;
      g[18] = 8; g[20] = 7;
      g[3*NN] = 10; g[3*NN+1] = 11;
      run_geno("R2");
      chk("R2 function word", {32'd0, out_words[31:0]}, {32'd0, fn_ref(f, inw[0], inw[1])});
    end

    // R4 R5: random legal grids and random row data
    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < NIN; i++) inw[i] = $urandom;
      rand_geno();
      run_geno("R4");
    end

    // R6: illegal node links
    rand_geno(); g[3*3] = 6;      run_geno("R6 same column");
    rand_geno(); g[3*0+1] = 6;    run_geno("R6 right column");
    rand_geno(); g[3*6] = 4;      run_geno("R6 too far left");
    rand_geno(); g[3*5+1] = 13;   run_geno("R6 index range");
    // R7: illegal output selectors
    rand_geno(); g[3*NN] = 4;     run_geno("R7 early node");
    rand_geno(); g[3*NN+1] = 1;   run_geno("R7 primary input");
    rand_geno(); g[3*NN] = 14;    run_geno("R7 index range");
    // recovery after an error
    rand_geno(); run_geno("R8 recovery");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule